// File: doc/BRIEF.md
# Response Ring Writer with Coalesced Interrupt

This block is the controller end of a circular response buffer held in system memory. Each link response has two 32-bit words: a response word and an extended word. The block writes both words as one 64-bit entry into the ring. The low half of that write holds the response word and the high half holds the extended word. Each slot is eight bytes wide and sits at the ring base plus eight times the slot index. A hardware write pointer names the most recently filled slot. It advances modulo the programmed ring size, which is 2, 16 or 256 entries.

Software controls the block through a small register port. The registers hold the write pointer (with a self-acting reset bit), the interrupt threshold, a control register with separate write-enable and interrupt-enable bits, a status register cleared by writing one, and the ring-size code. The block does not raise the interrupt on every entry. It counts accepted entries and sets its status flag once the programmed number has been stored.

The link side never stalls. A response is always consumed. It is dropped instead of stored when writes are disabled. It is also dropped when it is marked unsolicited while the global accept-unsolicited input is low.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset, the register reads are: pointer 0, threshold 1, control 0, status 0, size code 2. No memory write and no interrupt are pending.
- R2: `rsp_ready` is high in every cycle, including cycles in which the response is dropped.
- R3: A response is accepted when `rsp_valid` is high and control bit 0 (write enable, offset 2) is set. One cycle later `mem_wr_valid` pulses. `mem_wr_addr` is `ring_base + 8*idx`, where idx = pointer + 1 modulo the ring size. `mem_wr_data` is {extended word, response word}, and the pointer becomes idx.
- R4: Size code (offset 4, bits 1:0) 2 gives 256 entries, 1 gives 16 and 0 gives 2. The pointer wraps to 0 after the last slot. A write of code 3 is ignored.
- R5: Writing offset 0 with bit 15 set clears the pointer and the entry counter. A response offered in that same cycle is dropped. The next accepted response goes to slot 1.
- R6: While write enable is 0, offered responses produce no memory write. After write enable is cleared, bit 0 of the control register reads 0 from the next cycle on.
- R7: A response whose extended word has bit 4 set is stored only while `unsol_accept` is high. Responses with bit 4 clear are not affected by `unsol_accept`.
- R8: The threshold (offset 1, bits 7:0; 0 means 256) sets N. Status bit 0 (offset 3) sets when the N-th entry is accepted since the last time it was set or the pointer was reset. The entry counter then returns to 0.
- R9: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. If a clear and a new set happen in the same cycle, the set wins.
- R10: `irq` is high exactly when status bit 0 and control bit 1 (interrupt enable) are both set.
- R11: `reg_rdata` shows the register selected by `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 pointer, 1 threshold, 2 control, 3 status, 4 size) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| rsp_valid | input | 1 | Link response present |
| rsp_ready | output | 1 | Response consumed (always high) |
| rsp_word | input | 32 | Response word |
| rsp_ext | input | 32 | Extended word (bit 4 unsolicited, bits 3:0 codec address) |
| unsol_accept | input | 1 | Global permission to store unsolicited responses |
| ring_base | input | 32 | Byte address of slot 0 |
| mem_wr_valid | output | 1 | 64-bit memory write request |
| mem_wr_addr | output | 32 | Byte address of the write |
| mem_wr_data | output | 64 | {extended word, response word} |
| irq | output | 1 | Response interrupt request |

## Verification
A table of single responses is applied while three inputs are varied: write enable, the unsolicited flag and `unsol_accept`. The table separates the stored responses from the three ways a response can be dropped. It also confirms that drops do not advance the slot index or the interrupt count, with N = 3. Long runs of responses at each ring size separate a correct wrap from an off-by-one at the last slot. A run of 256 entries with threshold 0 separates "0 means 256" from "0 means never" and from "0 means every entry". Two directed same-cycle collisions check the priorities: pointer reset against a response, and a status clear against a new status set.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;
    localparam logic [2:0] OFS_WPTR = 3'd0;
    localparam logic [2:0] OFS_RCNT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_STAT = 3'd3;
    localparam logic [2:0] OFS_SIZE = 3'd4;

    localparam int WP_RST_BIT = 15;
    localparam int CTRL_WEN   = 0;
    localparam int CTRL_IEN   = 1;
    localparam int STAT_RSP   = 0;
    localparam int EXT_UNSOL  = 4;

    localparam logic [1:0] SZ_2   = 2'd0;
    localparam logic [1:0] SZ_16  = 2'd1;
    localparam logic [1:0] SZ_256 = 2'd2;
    localparam logic [1:0] SZ_BAD = 2'd3;
endpackage

// File: rtl/rsp_gate.sv
module rsp_gate (
    input  logic valid,
    input  logic unsol,
    input  logic wr_en,
    input  logic unsol_ok,
    input  logic blocked,
    output logic take
);
    always_comb begin
        take = valid && wr_en && !blocked && (!unsol || unsol_ok);
    end
endmodule

// File: rtl/ring_index_step.sv
module ring_index_step #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] cur,
    input  logic [1:0]       size_code,
    output logic [IDX_W-1:0] nxt
);
    import rsp_ring_pkg::*;
    localparam int BITS16 = (IDX_W < 4) ? IDX_W : 4;
    localparam logic [IDX_W-1:0] FULL   = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] MASK16 = FULL >> (IDX_W - BITS16);
    localparam logic [IDX_W-1:0] MASK2  = IDX_W'(1);

    logic [IDX_W-1:0] mask;

    always_comb begin
        case (size_code)
            SZ_2:    mask = MASK2;
            SZ_16:   mask = MASK16;
            default: mask = FULL;
        endcase
        nxt = (cur + IDX_W'(1)) & mask;
    end
endmodule

// File: rtl/rsp_irq_counter.sv
module rsp_irq_counter #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             hit
);
    logic [CNT_W:0] limit;
    logic [CNT_W:0] sum;

    always_comb begin
        limit   = {(thresh == '0), thresh};
        sum     = {1'b0, cnt} + (CNT_W+1)'(1);
        hit     = (sum == limit);
        cnt_inc = sum[CNT_W-1:0];
    end
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer #(
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [31:0]       rsp_word,
    input  logic [31:0]       rsp_ext,
    input  logic              unsol_accept,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [63:0]       mem_wr_data,
    output logic              irq
);
    import rsp_ring_pkg::*;

    localparam int SLOT_SH = 3;

    typedef struct packed {
        logic [IDX_W-1:0]  wp;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  thresh;
        logic              wen;
        logic              ien;
        logic              sts;
        logic [1:0]        size;
        logic              wr_v;
        logic [ADDR_W-1:0] wr_addr;
        logic [63:0]       wr_data;
    } state_t;

    state_t q, d;

    logic             wp_rst_wr;
    logic             take;
    logic [IDX_W-1:0] wp_next;
    logic [CNT_W-1:0] cnt_inc;
    logic             cnt_hit;
    logic             unused_wdata;

    assign unused_wdata = ^{1'b0, reg_wdata[14:CNT_W]};
    assign wp_rst_wr = reg_wr && (reg_addr == OFS_WPTR) && reg_wdata[WP_RST_BIT];

    rsp_gate u_gate (
        .valid    (rsp_valid),
        .unsol    (rsp_ext[EXT_UNSOL]),
        .wr_en    (q.wen),
        .unsol_ok (unsol_accept),
        .blocked  (wp_rst_wr),
        .take     (take)
    );

    ring_index_step #(.IDX_W(IDX_W)) u_step (
        .cur       (q.wp),
        .size_code (q.size),
        .nxt       (wp_next)
    );

    rsp_irq_counter #(.CNT_W(CNT_W)) u_cnt (
        .cnt     (q.cnt),
        .thresh  (q.thresh),
        .cnt_inc (cnt_inc),
        .hit     (cnt_hit)
    );

    always_comb begin
        d      = q;
        d.wr_v = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_RCNT: d.thresh = reg_wdata[CNT_W-1:0];
                OFS_CTRL: begin
                    d.wen = reg_wdata[CTRL_WEN];
                    d.ien = reg_wdata[CTRL_IEN];
                end
                OFS_STAT: if (reg_wdata[STAT_RSP]) d.sts = 1'b0;
                OFS_SIZE: if (reg_wdata[1:0] != SZ_BAD) d.size = reg_wdata[1:0];
                default: ;
            endcase
        end
        if (wp_rst_wr) begin
            d.wp  = '0;
            d.cnt = '0;
        end else if (take) begin
            d.wp      = wp_next;
            d.wr_v    = 1'b1;
            d.wr_addr = ring_base + (ADDR_W'(wp_next) << SLOT_SH);
            d.wr_data = {rsp_ext, rsp_word};
            if (cnt_hit) begin
                d.cnt = '0;
                d.sts = 1'b1;
            end else begin
                d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.thresh <= CNT_W'(1);
            q.size   <= SZ_256;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_WPTR: reg_rdata = 16'(q.wp);
            OFS_RCNT: reg_rdata = 16'(q.thresh);
            OFS_CTRL: reg_rdata = 16'({q.ien, q.wen});
            OFS_STAT: reg_rdata = 16'(q.sts);
            OFS_SIZE: reg_rdata = 16'(q.size);
            default:  reg_rdata = '0;
        endcase
    end

    assign rsp_ready    = 1'b1;
    assign mem_wr_valid = q.wr_v;
    assign mem_wr_addr  = q.wr_addr;
    assign mem_wr_data  = q.wr_data;
    assign irq          = q.sts && q.ien;

    logic [IDX_W-1:0] wp_cur;
    logic [CNT_W-1:0] cnt_cur;
    logic             sts_cur;
    logic             wen_cur;
    assign wp_cur  = q.wp;
    assign cnt_cur = q.cnt;
    assign sts_cur = q.sts;
    assign wen_cur = q.wen;
endmodule

// File: rtl/rsp_ring_writer_chk.sv
module rsp_ring_writer_chk #(
    parameter int IDX_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic             wp_rst_bit,
    input logic             w1c_bit,
    input logic             rsp_valid,
    input logic             rsp_unsol,
    input logic             unsol_accept,
    input logic             mem_wr_valid,
    input logic [IDX_W-1:0] wp_cur,
    input logic [CNT_W-1:0] cnt_cur,
    input logic             sts_cur,
    input logic             wen_cur
);
    // R5
    wp_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && wp_rst_bit)
        |=> (wp_cur == '0 && cnt_cur == '0 && !mem_wr_valid));

    // R6
    wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !wen_cur) |=> !mem_wr_valid);

    // R7
    unsol_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_unsol && !unsol_accept) |=> !mem_wr_valid);

    // R3
    wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_valid) |-> ($past(rsp_valid) && $past(wen_cur)));

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_cur) |-> (cnt_cur == '0 && mem_wr_valid));

    // R9
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && w1c_bit && !rsp_valid) |=> !sts_cur);
endmodule

bind rsp_ring_writer rsp_ring_writer_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wp_rst_bit   (reg_wdata[15]),
    .w1c_bit      (reg_wdata[0]),
    .rsp_valid    (rsp_valid),
    .rsp_unsol    (rsp_ext[4]),
    .unsol_accept (unsol_accept),
    .mem_wr_valid (mem_wr_valid),
    .wp_cur       (wp_cur),
    .cnt_cur      (cnt_cur),
    .sts_cur      (sts_cur),
    .wen_cur      (wen_cur)
);

// File: tb/rsp_ring_writer_tb.sv
module rsp_ring_writer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_word = '0;
    logic [31:0] rsp_ext = '0;
    logic        unsol_accept = 1'b0;
    logic [31:0] ring_base = 32'h1000_0000;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rsp_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_word(rsp_word), .rsp_ext(rsp_ext),
        .unsol_accept(unsol_accept), .ring_base(ring_base),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send(input logic [31:0] w, input logic [31:0] e);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_word = w; rsp_ext = e;
        #1 chk("R2 ready", 64'(rsp_ready), 64'd1);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
    endtask

    typedef struct packed {
        logic       wen;
        logic       acc;
        logic       unsol;
        logic       exp_wr;
        logic [7:0] exp_idx;
        logic       exp_irq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'd2, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd3, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd4, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd5, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd6, 1'b1}
    };

    initial begin
        logic [15:0] v;
        logic [31:0] w;
        logic [31:0] e;

        #9 rst_n = 1'b1;

        // R1 and R11: reset values through the register map
        rd(3'd0, v); chk("R1 pointer", 64'(v), 64'd0);
        rd(3'd1, v); chk("R1 threshold", 64'(v), 64'd1);
        rd(3'd2, v); chk("R1 control", 64'(v), 64'd0);
        rd(3'd3, v); chk("R1 status", 64'(v), 64'd0);
        rd(3'd4, v); chk("R11 size", 64'(v), 64'd2);
        chk("R1 no write", 64'(mem_wr_valid), 64'd0);
        chk("R1 no irq", 64'(irq), 64'd0);

        // Vector table, threshold 3
        wr(3'd1, 16'd3);
        wr(3'd0, 16'h8000);
        for (int i = 0; i < NV; i++) begin
            wr(3'd2, {14'd0, 1'b1, VEC[i].wen});
            unsol_accept = VEC[i].acc;
            w = 32'hA500_0000 | 32'(i);
            e = {27'd0, VEC[i].unsol, 4'(i)};
            send(w, e);
            chk("R3 R6 R7 write strobe", 64'(mem_wr_valid), 64'(VEC[i].exp_wr));
            if (VEC[i].exp_wr) begin
                chk("R3 slot address", 64'(mem_wr_addr), 64'(ring_base + 32'(VEC[i].exp_idx) * 8));
                chk("R3 entry data", mem_wr_data, {e, w});
            end
            chk("R8 R10 irq", 64'(irq), 64'(VEC[i].exp_irq));
            if (VEC[i].exp_irq) begin
                wr(3'd3, 16'd1);
                chk("R9 cleared", 64'(irq), 64'd0);
            end
        end
        rd(3'd0, v); chk("R3 pointer after table", 64'(v), 64'd6);

        // R6: control readback after clearing write enable
        wr(3'd2, 16'd3);
        rd(3'd2, v); chk("R6 enable set", 64'(v), 64'd3);
        wr(3'd2, 16'd2);
        rd(3'd2, v); chk("R6 enable reads 0", 64'(v & 16'd1), 64'd0);
        wr(3'd2, 16'd3);

        // R5: pointer reset collides with a response
        unsol_accept = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h8000;
        rsp_valid = 1'b1; rsp_word = 32'h1; rsp_ext = 32'h0;
        @(posedge clk); #1;
        reg_wr = 1'b0; rsp_valid = 1'b0;
        chk("R5 collided response dropped", 64'(mem_wr_valid), 64'd0);
        rd(3'd0, v); chk("R5 pointer zero", 64'(v), 64'd0);
        send(32'h2, 32'h0);
        chk("R5 first slot is 1", 64'(mem_wr_addr), 64'(ring_base + 32'd8));

        // R4 and R8: 256-entry wrap with threshold 0 meaning 256
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h8000);
        for (int i = 1; i < 256; i++) send(32'(i), 32'h0);
        chk("R8 no irq at 255", 64'(irq), 64'd0);
        rd(3'd0, v); chk("R4 pointer 255", 64'(v), 64'd255);
        send(32'hFF, 32'h0);
        chk("R4 wrap to slot 0", 64'(mem_wr_addr), 64'(ring_base));
        chk("R8 irq at 256", 64'(irq), 64'd1);
        wr(3'd3, 16'd1);

        // R4: 16-entry ring
        wr(3'd4, 16'd1);
        rd(3'd4, v); chk("R4 size 16 code", 64'(v), 64'd1);
        wr(3'd0, 16'h8000);
        for (int i = 1; i < 16; i++) send(32'(i), 32'h0);
        rd(3'd0, v); chk("R4 pointer 15", 64'(v), 64'd15);
        send(32'h10, 32'h0);
        chk("R4 16 wraps", 64'(mem_wr_addr), 64'(ring_base));

        // R4: 2-entry ring and rejected code
        wr(3'd4, 16'd0);
        wr(3'd0, 16'h8000);
        send(32'h1, 32'h0);
        chk("R4 size 2 slot 1", 64'(mem_wr_addr), 64'(ring_base + 32'd8));
        send(32'h2, 32'h0);
        chk("R4 size 2 wraps", 64'(mem_wr_addr), 64'(ring_base));
        wr(3'd4, 16'd3);
        rd(3'd4, v); chk("R4 code 3 ignored", 64'(v), 64'd0);
        wr(3'd4, 16'd2);

        // R9: set wins over clear, write of 0 keeps status
        wr(3'd1, 16'd1);
        wr(3'd0, 16'h8000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'd1;
        rsp_valid = 1'b1; rsp_word = 32'h77; rsp_ext = 32'h0;
        @(posedge clk); #1;
        reg_wr = 1'b0; rsp_valid = 1'b0;
        rd(3'd3, v); chk("R9 set wins", 64'(v), 64'd1);
        wr(3'd3, 16'd0);
        rd(3'd3, v); chk("R9 write 0 no effect", 64'(v), 64'd1);

        // R10: interrupt enable masks the request
        wr(3'd2, 16'd1);
        chk("R10 masked", 64'(irq), 64'd0);
        wr(3'd2, 16'd3);
        chk("R10 unmasked", 64'(irq), 64'd1);
        wr(3'd3, 16'd1);
        chk("R9 W1C", 64'(irq), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule